// File: doc/BRIEF.md
# SPI Master/Slave Controller with Mode-Fault Demotion

This block is a byte-wide SPI peripheral that software steers through three byte registers on a simple read/write bus. In master mode it generates SCK from the system clock, shifts a byte out on MOSI while taking one in on MISO, and raises a completion flag when the eighth bit is done. In slave mode it follows an external SCK and slave-select, receiving on MOSI and driving MISO only while it is selected.

The controller also guards against two masters driving the bus at once. When it is master and its slave-select pin is treated as an input, a low level on that pin means another master has selected it. The block then drops its master role, releases SCK and MOSI, and sets the completion flag so that software can see what happened. The master role stays off until software writes it back. In slave mode, a deselect in the middle of a byte throws away the partial byte and restarts the bit count.

An interrupt line combines the completion flag, an enable bit in the control register and an external global-enable input.

Top module: `spi_mm_ctrl`

## Requirements
- R1: After reset the control and status registers read 0, irq is low, all three output enables are low and sck_o is low.
- R2: Address 0 is the control register, read back as written: bit 7 interrupt enable, bit 6 block enable, bit 5 data order, bit 4 master select, bit 3 clock polarity, bit 2 clock phase, bits 1:0 rate select. Address 1 is status, with the completion flag in bit 7 and zeros elsewhere. Address 2 is data. Address 3 reads 0.
- R3: Writing the data register while enabled, master and idle starts an 8-bit exchange. The received byte is then readable at address 2. Data order 0 sends MSB first and data order 1 sends LSB first, in both directions.
- R4: SCK idles at the clock-polarity level. With clock phase 0, data is sampled on the leading edge and changed on the trailing edge. With clock phase 1, data is changed on the leading edge and sampled on the trailing edge.
- R5: In master mode, the rate select values 0, 1, 2 and 3 give an SCK half-period of 2, 8, 32 and 64 system clocks, which divides the clock by 4, 16, 64 or 128.
- R6: The completion flag sets after each full byte in either mode. It clears when status is read while the flag is set and the data register is then read or written.
- R7: irq is high exactly when the completion flag, the interrupt enable bit and irq_glb_en are all high.
- R8: In slave mode, the block receives on mosi_i and drives miso_o, with miso_oe high only while it is enabled and selected (ss_i low).
- R9: In slave mode, ss_i going high discards any partly received byte and restarts the bit count, so the partial byte neither sets the flag nor shifts the next byte.
- R10: When the block is enabled and master, ss_dir_out is 0 and ss_i is low, the master bit clears and the completion flag sets. sck_oe and mosi_oe then go low.
- R11: After such a demotion the master bit stays 0 until a control write has bit 4 set.
- R12: With ss_dir_out at 1, ss_i has no effect in master mode: transfers complete and the master bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (side effects on status and data) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| irq_glb_en | input | 1 | External global interrupt enable |
| irq | output | 1 | Interrupt request |
| ss_dir_out | input | 1 | 1: the slave-select pin is an output and is ignored by the SPI logic |
| ss_i | input | 1 | Slave-select pin level, active low |
| sck_i | input | 1 | SCK pin level, used in slave mode |
| sck_o | output | 1 | SCK driven in master mode |
| sck_oe | output | 1 | SCK output enable |
| mosi_i | input | 1 | MOSI pin level, used in slave mode |
| mosi_o | output | 1 | MOSI data in master mode |
| mosi_oe | output | 1 | MOSI output enable |
| miso_i | input | 1 | MISO pin level, used in master mode |
| miso_o | output | 1 | MISO data in slave mode |
| miso_oe | output | 1 | MISO output enable |

## Verification
The checker tests, on every cycle, the rules that need no knowledge of the data: irq never rises without its enables, the flag rises only after a completed byte or a mode fault, a mode fault removes master mode and both master output enables, master mode returns only through a control write, a master with its select pin as output keeps its role, MISO is driven only by an enabled slave, and an idle SCK sits at the polarity level. The bench's scenarios are the only evidence for the rest. These are the bit values and their order on MOSI and MISO in all four modes, the measured SCK half-periods, the two-step flag clear, and the partial slave byte that is dropped on deselect.

// File: rtl/spi_mm_pkg.sv
// Package: shared types and constants for the SPI master/slave controller.
// Assumes an 8-bit register bus and a fixed control-register bit layout.
package spi_mm_pkg;

    localparam int BYTE_W = 8;

    // Control register layout, bit 7 down to bit 0.
    typedef struct packed {
        logic       irq_en;
        logic       en;
        logic       lsb_first;
        logic       master;
        logic       cpol;
        logic       cpha;
        logic [1:0] rate;
    } ctrl_t;

    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_STAT = 2'd1,
        ADDR_DATA = 2'd2,
        ADDR_NONE = 2'd3
    } reg_addr_e;

    // SCK half-period in system clocks for each rate code.
    function automatic logic [6:0] half_cycles(input logic [1:0] rate);
        case (rate)
            2'd0:    half_cycles = 7'd2;
            2'd1:    half_cycles = 7'd8;
            2'd2:    half_cycles = 7'd32;
            default: half_cycles = 7'd64;
        endcase
    endfunction

endpackage

// File: rtl/spi_mm_sync.sv
// Module: multi-stage flop synchroniser for a vector of asynchronous pins.
// Assumes each bit is independent (no bus coherency needed).
module spi_mm_sync #(
    parameter int             W       = 2,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    // Shift the pin values through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/spi_mm_clkgen.sv
// Module: master SCK generator. It toggles SCK every half-period while run is
// high and reports each toggle with its index within the frame.
// Assumes run drops no later than the cycle after the last edge.
module spi_mm_clkgen #(
    parameter int  EDGES = 16,
    localparam int EW    = $clog2(EDGES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          cpol,
    input  logic [1:0]    rate,
    output logic          sck,
    output logic          edge_pls,
    output logic [EW-1:0] edge_idx
);

    logic [6:0] cnt;
    logic [6:0] half;

    assign half     = spi_mm_pkg::half_cycles(rate);
    assign edge_pls = run && (cnt == half - 7'd1);

    // Count the half-period and toggle SCK; park at the polarity level when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            sck      <= 1'b0;
            edge_idx <= '0;
        end else if (!run) begin
            cnt      <= '0;
            sck      <= cpol;
            edge_idx <= '0;
        end else if (edge_pls) begin
            cnt      <= '0;
            sck      <= ~sck;
            edge_idx <= edge_idx + 1'b1;
        end else begin
            cnt      <= cnt + 7'd1;
        end
    end

endmodule

// File: rtl/spi_mm_regs.sv
// Module: register file for control, status and data. It also holds the
// completion flag and its two-step clear, and the mode-fault master clear.
// Assumes done and fault are single-cycle pulses.
module spi_mm_regs #(
    parameter int  REG_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel,
    input  logic               wr,
    input  logic               rd,
    input  logic [1:0]         addr,
    input  logic [REG_W-1:0]   wdata,
    input  logic [REG_W-1:0]   rx_byte,
    input  logic               done,
    input  logic               fault,
    output spi_mm_pkg::ctrl_t  ctrl_q,
    output logic               flag_q,
    output logic               data_wr,
    output logic [REG_W-1:0]   rdata
);
    import spi_mm_pkg::*;

    logic ctrl_wr;
    logic stat_rd;
    logic data_acc;
    logic armed_q;

    assign ctrl_wr  = sel && wr && (addr == ADDR_CTRL);
    assign stat_rd  = sel && rd && (addr == ADDR_STAT);
    assign data_wr  = sel && wr && (addr == ADDR_DATA);
    assign data_acc = sel && (rd || wr) && (addr == ADDR_DATA);

    // Control register: software write, with a mode fault forcing master off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            if (ctrl_wr) ctrl_q <= ctrl_t'(wdata[7:0]);
            if (fault)   ctrl_q.master <= 1'b0;
        end
    end

    // Completion flag: set on done or fault; cleared by a status read and then a data access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q  <= 1'b0;
            armed_q <= 1'b0;
        end else if (done || fault) begin
            flag_q  <= 1'b1;
            armed_q <= 1'b0;
        end else if (data_acc && armed_q) begin
            flag_q  <= 1'b0;
            armed_q <= 1'b0;
        end else if (stat_rd && flag_q) begin
            armed_q <= 1'b1;
        end
    end

    // Read multiplexer.
    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_CTRL: rdata[7:0] = ctrl_q;
            ADDR_STAT: rdata[REG_W-1] = flag_q;
            ADDR_DATA: rdata = rx_byte;
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/spi_mm_shifter.sv
// Module: transmit/receive shift engine for master and slave modes. It decodes
// sample and shift events from the master edge index or from synchronised
// slave SCK edges, and handles the slave deselect reset.
// Assumes sck_s and ss_s are already synchronised to clk.
module spi_mm_shifter #(
    parameter int  DATA_W = 8,
    localparam int BW     = $clog2(DATA_W),
    localparam int EW     = $clog2(2*DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              master,
    input  logic              lsb_first,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              start,
    input  logic              wr_data,
    input  logic [DATA_W-1:0] wdata,
    input  logic              m_edge,
    input  logic [EW-1:0]     m_idx,
    input  logic              sck_s,
    input  logic              ss_s,
    input  logic              sdi,
    input  logic              abort,
    output logic              sdo,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rx_byte
);

    logic [DATA_W-1:0] tx_sh, tx_hold, rx_sh, rx_next;
    logic [BW-1:0]     bit_cnt;
    logic              s_first, sck_d;
    logic              m_lead, m_last, s_act, s_rise, s_fall, s_lead, s_trail;
    logic              do_sample, do_shift, byte_end, frame_clr;

    assign m_lead  = !m_idx[0];
    assign m_last  = (m_idx == EW'(2*DATA_W-1));
    assign s_act   = en && !master && !ss_s;
    assign s_rise  = sck_s && !sck_d;
    assign s_fall  = !sck_s && sck_d;
    assign s_lead  = s_act && (cpol ? s_fall : s_rise);
    assign s_trail = s_act && (cpol ? s_rise : s_fall);

    // Decode the sample and shift events for the active mode and phase.
    always_comb begin
        if (master) begin
            do_sample = busy && m_edge && (cpha ? !m_lead : m_lead);
            do_shift  = busy && m_edge && (cpha ? (m_lead && m_idx != '0) : !m_lead);
        end else begin
            do_sample = cpha ? s_trail : s_lead;
            do_shift  = cpha ? (s_lead && !s_first) : s_trail;
        end
    end

    assign rx_next   = lsb_first ? {sdi, rx_sh[DATA_W-1:1]} : {rx_sh[DATA_W-2:0], sdi};
    assign sdo       = lsb_first ? tx_sh[0] : tx_sh[DATA_W-1];
    assign byte_end  = do_sample && (bit_cnt == BW'(DATA_W-1));
    assign done      = master ? (busy && m_edge && m_last) : byte_end;
    assign frame_clr = !en || abort || (!master && ss_s) || start;

    // Delay the synchronised SCK by one cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_d <= 1'b0;
        else        sck_d <= sck_s;
    end

    // Master busy: set on start, cleared on the final edge, on abort or when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)                busy <= 1'b0;
        else if (!en || abort)     busy <= 1'b0;
        else if (start)            busy <= 1'b1;
        else if (master && done)   busy <= 1'b0;
    end

    // Receive path and bit count; a frame clear drops any partial byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sh   <= '0;
            bit_cnt <= '0;
            s_first <= 1'b1;
            rx_byte <= '0;
        end else if (frame_clr) begin
            bit_cnt <= '0;
            s_first <= 1'b1;
        end else begin
            if (do_sample) begin
                rx_sh   <= rx_next;
                bit_cnt <= byte_end ? '0 : bit_cnt + 1'b1;
            end
            if (byte_end) begin
                rx_byte <= rx_next;
                s_first <= 1'b1;
            end else if (cpha && s_lead) begin
                s_first <= 1'b0;
            end
        end
    end

    // Hold register for the next transmit byte.
    always_ff @(posedge clk) begin
        if (!rst_n)       tx_hold <= '0;
        else if (wr_data) tx_hold <= wdata;
    end

    // Transmit shift register: loaded on start or while deselected, shifted on shift events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh <= '0;
        end else if (start) begin
            tx_sh <= wdata;
        end else if (!master && (ss_s || !en)) begin
            tx_sh <= wr_data ? wdata : tx_hold;
        end else if (do_shift) begin
            tx_sh <= lsb_first ? (tx_sh >> 1) : (tx_sh << 1);
        end
    end

endmodule

// File: rtl/spi_mm_ctrl.sv
// Module: top of the SPI master/slave controller. It connects registers, pin
// synchronisers, SCK generation and the shift engine, detects mode faults
// and drives pin enables and the interrupt request.
// Assumes pins are external to clk and need synchronising in slave mode.
module spi_mm_ctrl #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_sel,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       irq_glb_en,
    output logic       irq,
    input  logic       ss_dir_out,
    input  logic       ss_i,
    input  logic       sck_i,
    output logic       sck_o,
    output logic       sck_oe,
    input  logic       mosi_i,
    output logic       mosi_o,
    output logic       mosi_oe,
    input  logic       miso_i,
    output logic       miso_o,
    output logic       miso_oe
);
    import spi_mm_pkg::*;

    localparam int EDGES = 2 * BYTE_W;
    localparam int EW    = $clog2(EDGES);

    ctrl_t             ctrl_q;
    logic              flag_q, data_wr, busy, done, fault, start;
    logic              ss_s, sck_s, m_edge, sdo, sdi;
    logic [EW-1:0]     m_idx;
    logic [BYTE_W-1:0] rx_byte;
    logic [1:0]        pins_s;

    spi_mm_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({ss_i, sck_i}), .q(pins_s)
    );
    assign ss_s  = pins_s[1];
    assign sck_s = pins_s[0];

    assign fault = ctrl_q.en && ctrl_q.master && !ss_dir_out && !ss_s;
    assign start = data_wr && ctrl_q.en && ctrl_q.master && !busy && !fault;
    assign sdi   = ctrl_q.master ? miso_i : mosi_i;

    spi_mm_regs #(.REG_W(BYTE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .sel(bus_sel), .wr(bus_wr), .rd(bus_rd),
        .addr(bus_addr), .wdata(bus_wdata), .rx_byte(rx_byte), .done(done),
        .fault(fault), .ctrl_q(ctrl_q), .flag_q(flag_q), .data_wr(data_wr),
        .rdata(bus_rdata)
    );

    spi_mm_clkgen #(.EDGES(EDGES)) u_clkgen (
        .clk(clk), .rst_n(rst_n), .run(busy), .cpol(ctrl_q.cpol),
        .rate(ctrl_q.rate), .sck(sck_o), .edge_pls(m_edge), .edge_idx(m_idx)
    );

    spi_mm_shifter #(.DATA_W(BYTE_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .en(ctrl_q.en), .master(ctrl_q.master),
        .lsb_first(ctrl_q.lsb_first), .cpol(ctrl_q.cpol), .cpha(ctrl_q.cpha),
        .start(start), .wr_data(data_wr), .wdata(bus_wdata), .m_edge(m_edge),
        .m_idx(m_idx), .sck_s(sck_s), .ss_s(ss_s), .sdi(sdi), .abort(fault),
        .sdo(sdo), .busy(busy), .done(done), .rx_byte(rx_byte)
    );

    // Pin drivers and interrupt request.
    assign sck_oe  = ctrl_q.en && ctrl_q.master;
    assign mosi_oe = ctrl_q.en && ctrl_q.master;
    assign mosi_o  = sdo;
    assign miso_o  = sdo;
    assign miso_oe = ctrl_q.en && !ctrl_q.master && !ss_s;
    assign irq     = flag_q && ctrl_q.irq_en && irq_glb_en;

endmodule

// File: rtl/spi_mm_checker.sv
// Module: property checker for spi_mm_ctrl, attached by bind.
// Assumes the top-level internal names ctrl_q, flag_q, busy, done and fault.
module spi_mm_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_sel,
    input logic       bus_wr,
    input logic [1:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic       irq,
    input logic       irq_glb_en,
    input logic [7:0] ctrl_q,
    input logic       flag_q,
    input logic       busy,
    input logic       done,
    input logic       fault,
    input logic       ss_dir_out,
    input logic       sck_o,
    input logic       sck_oe,
    input logic       mosi_oe,
    input logic       miso_oe
);

    logic ctrl_write;
    assign ctrl_write = bus_sel && bus_wr && (bus_addr == 2'd0);

    p_irq_needs_enables_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_glb_en && ctrl_q[7] && flag_q));

    p_flag_has_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(done || fault));

    p_fault_demotes_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> (!ctrl_q[4] && flag_q && !sck_oe && !mosi_oe));

    p_master_by_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_q[4]) |-> $past(ctrl_write && bus_wdata[4]));

    p_ss_output_keeps_master_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[4] && ss_dir_out && !ctrl_write) |=> ctrl_q[4]);

    p_miso_only_slave_r8: assert property (@(posedge clk) disable iff (!rst_n)
        miso_oe |-> (ctrl_q[6] && !ctrl_q[4]));

    p_sck_idle_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy) && $stable(ctrl_q[3])) |-> (sck_o == ctrl_q[3]));

endmodule

bind spi_mm_ctrl spi_mm_checker u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq(irq),
    .irq_glb_en(irq_glb_en), .ctrl_q(ctrl_q), .flag_q(flag_q), .busy(busy),
    .done(done), .fault(fault), .ss_dir_out(ss_dir_out), .sck_o(sck_o),
    .sck_oe(sck_oe), .mosi_oe(mosi_oe), .miso_oe(miso_oe)
);

// File: tb/spi_mm_ctrl_bench.sv
// Bench: directed corner cases plus seeded random master and slave transfers.
module spi_mm_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 0, bus_wr = 0, bus_rd = 0;
    logic [1:0] bus_addr = 0;
    logic [7:0] bus_wdata = 0, bus_rdata;
    logic       irq_glb_en = 0, irq;
    logic       ss_dir_out = 0, ss_i = 1, sck_i = 0;
    logic       sck_o, sck_oe, mosi_i = 0, mosi_o, mosi_oe;
    logic       miso_i = 0, miso_o, miso_oe;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    spi_mm_ctrl u_spi_mm_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_glb_en(irq_glb_en), .irq(irq),
        .ss_dir_out(ss_dir_out), .ss_i(ss_i), .sck_i(sck_i), .sck_o(sck_o),
        .sck_oe(sck_oe), .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
        .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_rd = 1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 0; bus_rd = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic bit_at(input logic [7:0] b, input int k, input logic lsb);
        return lsb ? b[k] : b[7-k];
    endfunction

    function automatic int exp_half(input logic [1:0] rate);
        case (rate)
            2'd0: return 2;
            2'd1: return 8;
            2'd2: return 32;
            default: return 64;
        endcase
    endfunction

    // Master transfer with the bench acting as the slave device.
    task automatic m_xfer(input logic [1:0] mode, input logic lsb, input logic [1:0] rate,
                          input logic [7:0] tx, input logic [7:0] slv,
                          input logic ie, input logic glb);
        logic [7:0] got_mosi, rd;
        logic       prev, cpha, cpol;
        int         edges, cyc, c0, c1, guard;
        cpol = mode[1]; cpha = mode[0];
        irq_glb_en = glb;
        got_mosi = '0; edges = 0; cyc = 0; c0 = 0; c1 = 0; guard = 0;
        wr_reg(2'd0, {ie, 1'b1, lsb, 1'b1, cpol, cpha, rate});
        if (!cpha) miso_i = bit_at(slv, 0, lsb);
        wr_reg(2'd2, tx);
        prev = sck_o;
        while (edges < 16 && guard < 3000) begin
            @(negedge clk);
            cyc++; guard++;
            if (sck_o != prev) begin
                logic lead, samp;
                int   k;
                prev = sck_o;
                lead = (edges % 2) == 0;
                samp = cpha ? !lead : lead;
                k    = edges / 2;
                if (edges == 0) c0 = cyc;
                if (edges == 1) c1 = cyc;
                if (samp) begin
                    if (lsb) got_mosi[k] = mosi_o; else got_mosi[7-k] = mosi_o;
                end else if (cpha) begin
                    miso_i = bit_at(slv, k, lsb);
                end else if (k < 7) begin
                    miso_i = bit_at(slv, k + 1, lsb);
                end
                edges++;
            end
        end
        idle(2);
        check("R5 sck half-period", c1 - c0, exp_half(rate));
        check("R4 sck back at idle level", sck_o, cpol);
        check("R3 bits seen on mosi", got_mosi, tx);
        check("R7 irq after transfer", irq, ie & glb);
        rd_reg(2'd1, rd);
        check("R6 flag set after byte", rd, 8'h80);
        rd_reg(2'd2, rd);
        check("R3 received byte", rd, slv);
        rd_reg(2'd1, rd);
        check("R6 flag cleared by status then data", rd, 8'h00);
    endtask

    // Slave transfer with the bench acting as master; abort_at >= 0 deselects early.
    task automatic s_xfer(input logic [1:0] mode, input logic lsb, input logic do_write,
                          input logic [7:0] dev_tx, input logic [7:0] mst_tx,
                          input int abort_at, input logic [7:0] exp_miso);
        logic [7:0] got_miso, rd;
        logic       cpol, cpha;
        int         nbits;
        localparam int H = 8;
        cpol = mode[1]; cpha = mode[0];
        got_miso = '0;
        nbits = (abort_at >= 0) ? abort_at : 8;
        sck_i = cpol; ss_i = 1;
        wr_reg(2'd0, {1'b0, 1'b1, lsb, 1'b0, cpol, cpha, 2'b00});
        if (do_write) wr_reg(2'd2, dev_tx);
        idle(4);
        check("R8 miso released while deselected", miso_oe, 0);
        ss_i = 0;
        idle(4);
        check("R8 miso driven while selected", miso_oe, 1);
        for (int k = 0; k < nbits; k++) begin
            if (!cpha) begin
                mosi_i = bit_at(mst_tx, k, lsb);
                idle(H);
                if (lsb) got_miso[k] = miso_o; else got_miso[7-k] = miso_o;
                sck_i = ~cpol;
                idle(H);
                sck_i = cpol;
            end else begin
                sck_i = ~cpol;
                mosi_i = bit_at(mst_tx, k, lsb);
                idle(H);
                if (lsb) got_miso[k] = miso_o; else got_miso[7-k] = miso_o;
                sck_i = cpol;
            end
            idle(H);
        end
        ss_i = 1;
        idle(5);
        rd_reg(2'd1, rd);
        if (abort_at >= 0) begin
            check("R9 partial byte sets no flag", rd, 8'h00);
        end else begin
            check("R6 slave flag set", rd, 8'h80);
            rd_reg(2'd2, rd);
            check("R8 slave received byte", rd, mst_tx);
            check("R8 slave bits on miso", got_miso, exp_miso);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        void'($urandom(32'h1234abcd));
        idle(3);
        rst_n = 1;
        idle(2);

        // R1 reset state
        rd_reg(2'd0, rd); check("R1 control after reset", rd, 0);
        rd_reg(2'd1, rd); check("R1 status after reset", rd, 0);
        check("R1 irq after reset", irq, 0);
        check("R1 enables after reset", {sck_oe, mosi_oe, miso_oe}, 0);
        check("R1 sck after reset", sck_o, 0);

        // R2 register layout readback (block disabled)
        wr_reg(2'd0, 8'hAD);
        rd_reg(2'd0, rd); check("R2 control readback", rd, 8'hAD);
        rd_reg(2'd3, rd); check("R2 unused address reads 0", rd, 0);
        wr_reg(2'd0, 8'h00);

        // Directed master transfers across modes, orders and rates
        m_xfer(2'd0, 1'b0, 2'd0, 8'hA5, 8'h3C, 1'b1, 1'b1);
        m_xfer(2'd1, 1'b1, 2'd1, 8'h81, 8'h7E, 1'b1, 1'b0);
        m_xfer(2'd2, 1'b0, 2'd2, 8'h01, 8'h80, 1'b0, 1'b1);
        m_xfer(2'd3, 1'b1, 2'd3, 8'hFF, 8'h00, 1'b1, 1'b1);

        // Random master transfers
        for (int i = 0; i < 20; i++) begin
            m_xfer(2'($urandom), 1'($urandom), 2'($urandom % 3),
                   8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom));
        end

        // Slave transfers in all modes
        s_xfer(2'd0, 1'b0, 1'b1, 8'hC3, 8'h5A, -1, 8'hC3);
        s_xfer(2'd1, 1'b1, 1'b1, 8'h12, 8'hE7, -1, 8'h12);
        s_xfer(2'd2, 1'b0, 1'b1, 8'h96, 8'h0F, -1, 8'h96);
        s_xfer(2'd3, 1'b1, 1'b1, 8'h4B, 8'hB4, -1, 8'h4B);
        for (int i = 0; i < 6; i++) begin
            logic [7:0] dv;
            dv = 8'($urandom);
            s_xfer(2'($urandom), 1'($urandom), 1'b1, dv, 8'($urandom), -1, dv);
        end

        // R9 deselect mid-byte, then a full byte with the same held data
        s_xfer(2'd0, 1'b0, 1'b1, 8'h6D, 8'hFF, 3, 8'h00);
        s_xfer(2'd0, 1'b0, 1'b0, 8'h6D, 8'h29, -1, 8'h6D);
        s_xfer(2'd3, 1'b0, 1'b1, 8'hD2, 8'h00, 5, 8'h00);
        s_xfer(2'd3, 1'b0, 1'b0, 8'hD2, 8'hC8, -1, 8'hD2);

        // R10 mode fault with slave-select as input
        wr_reg(2'd0, 8'h00);
        ss_i = 1; ss_dir_out = 0; irq_glb_en = 1;
        wr_reg(2'd0, 8'hD0);
        check("R10 master enables before fault", {sck_oe, mosi_oe}, 2'b11);
        ss_i = 0;
        idle(5);
        rd_reg(2'd0, rd); check("R10 master bit cleared by fault", rd, 8'hC0);
        rd_reg(2'd1, rd); check("R10 flag set by fault", rd, 8'h80);
        check("R7 irq on fault", irq, 1);
        check("R10 sck/mosi released", {sck_oe, mosi_oe}, 2'b00);
        rd_reg(2'd2, rd);
        ss_i = 1;
        idle(5);
        rd_reg(2'd0, rd); check("R11 master stays clear after ss high", rd, 8'hC0);
        wr_reg(2'd0, 8'hC8);
        rd_reg(2'd0, rd); check("R11 write without master bit", rd, 8'hC8);
        wr_reg(2'd0, 8'hD0);
        rd_reg(2'd0, rd); check("R11 master restored by write", rd, 8'hD0);
        irq_glb_en = 0;
        check("R7 irq masked by global enable", irq, 0);

        // R10 fault during a transfer aborts it
        wr_reg(2'd0, 8'h53);
        wr_reg(2'd2, 8'h77);
        idle(40);
        ss_i = 0;
        idle(5);
        check("R10 fault mid-transfer releases sck", sck_oe, 0);
        rd_reg(2'd0, rd); check("R10 fault mid-transfer clears master", rd, 8'h43);
        rd_reg(2'd1, rd); rd_reg(2'd2, rd);
        ss_i = 1;
        idle(5);

        // R12 slave-select as output: low level has no effect
        ss_dir_out = 1; ss_i = 0;
        idle(4);
        m_xfer(2'd1, 1'b0, 2'd0, 8'h5C, 8'hA3, 1'b0, 1'b0);
        rd_reg(2'd0, rd); check("R12 master kept with ss as output", rd[4], 1);
        ss_i = 1; ss_dir_out = 0;

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule